// File: doc/BRIEF.md
# Comparator Event and Fault Controller

This block is the digital side of one external analog comparator. It takes the comparator's raw output bit, optionally inverts it, and brings it into the system clock domain through a short synchronizer. It then watches the synchronized level for a chosen kind of transition: rising, falling, either, or none. A matching transition sets a sticky event flag. Reading the status word clears that flag. The flag, gated by an interrupt mask, drives an interrupt line. A separate fault line can be driven either by the flag or by the synchronized level, and it is held low unless faults are enabled.

Software reaches the block through a simple 32-bit register bus. A write takes effect on the clock edge. Read data is combinational while the read strobe is high. Any read side effect happens on the edge that ends the read cycle.

The two input-select fields, the bias-current bit and the hysteresis field are only stored. Each one is presented on its own output pin for the analog macro. The configuration and analog-setting words can be locked by a keyed protection switch. A locked write is dropped, and a sticky violation bit records it. A self-clearing control bit returns every register to its reset value.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, every readable word is 0, and `irq`, `fault_out`, `cmp_on`, `sel_neg`, `sel_pos`, `bias_hi` and `hyst` are all 0.
- R2: Status bit 1 shows the comparator level after inversion. A change on `comp_in` appears there two clock edges later.
- R3: Mode bits 10:9 pick the transition that sets the event flag (status bit 0), and the flag appears three edges after the input change. The codes are:
  - 0: rising only.
  - 1: falling only.
  - 2: both.
  - 3: none.
- R4: While mode bit 8 (enable) is 0, no transition sets the event flag. Status bit 1 still tracks the input.
- R5: When mode bit 12 is 1, the comparator bit is inverted before synchronization, so transition detection acts on the inverted signal.
- R6: Reading the status word (offset 0x30) returns the flag and clears it. If a matching transition is detected in the same cycle as the read, the flag stays set.
- R7: Writing 1 to bit 0 at offset 0x24 sets the interrupt mask, and writing 1 to bit 0 at offset 0x28 clears it. The mask reads back at offset 0x2C bit 0 and at status bit 31. `irq` is high exactly when both the flag and the mask are set.
- R8: With mode bit 14 at 0, `fault_out` is 0. With bit 14 at 1, `fault_out` follows a source chosen by mode bit 13:
  - 0: the event flag.
  - 1: the synchronized level.
- R9: The mode word (offset 0x04) keeps only the bits in 0x7777. Its fields drive these pins:
  - Bits 2:0 drive `sel_neg`.
  - Bits 6:4 drive `sel_pos`.
  - Bit 8 drives `cmp_on`.

  The analog word (offset 0x94) keeps only the bits in 0x07. Bit 0 drives `bias_hi` and bits 2:1 drive `hyst`.
- R10: A write to offset 0xE4 changes the protection bit (bit 0) only when bits 31:8 equal 0x414343. Other writes there are ignored. Reads at 0xE4 return only bit 0.
- R11: While protection is on, writes to the mode and analog words are dropped and set the violation bit. The violation bit is read at offset 0xE8 bit 0 and is cleared by that read.
- R12: Writing 1 to bit 0 at offset 0x00 returns all registers, including the protection bit, to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| comp_in | input | 1 | Raw comparator output, asynchronous |
| irq | output | 1 | Interrupt: event flag AND mask |
| fault_out | output | 1 | Gated fault signal |
| cmp_on | output | 1 | Comparator enable to the analog macro |
| sel_neg | output | 3 | Negative-input select code |
| sel_pos | output | 3 | Positive-input select code |
| bias_hi | output | 1 | Bias-current select |
| hyst | output | 2 | Hysteresis select |

## Verification
The assertions assume three things about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- `comp_in` changes away from the clock edge.
- `comp_in` holds each level for at least three edges, so every transition reaches the second synchronizer stage and is compared against a stable previous sample.

The stimulus meets all three. Its tasks raise only one strobe at a time, on the falling clock edge. It changes `comp_in` only on the falling edge and then waits four or more cycles. Properties that expect a register to hold or set in the next cycle leave out cycles with a software-reset write, because that write clears everything on the same edge.

// File: rtl/cmpc_pkg.sv
`timescale 1ns/1ps
package cmpc_pkg;

  localparam int SEL_W  = 3;
  localparam int HYST_W = 2;

  // Register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h24;
  localparam logic [7:0] OFS_IDIS = 8'h28;
  localparam logic [7:0] OFS_IMSK = 8'h2C;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_ANA  = 8'h94;
  localparam logic [7:0] OFS_LOCK = 8'hE4;
  localparam logic [7:0] OFS_VIOL = 8'hE8;

  localparam logic [23:0] LOCK_KEY  = 24'h414343;
  localparam logic [31:0] MODE_KEEP = 32'h0000_7777;
  localparam logic [31:0] ANA_KEEP  = 32'h0000_0007;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic             flt_en;
    logic             flt_lvl;
    logic             inv;
    edge_sel_e        edge_sel;
    logic             on;
    logic [SEL_W-1:0] pos;
    logic [SEL_W-1:0] neg;
  } mode_t;

  typedef struct packed {
    logic [HYST_W-1:0] hyst;
    logic              bias_hi;
  } ana_t;

  function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic fault_pick(logic en, logic use_lvl, logic flag, logic lvl);
    return en & (use_lvl ? lvl : flag);
  endfunction

  function automatic mode_t mode_from_word(logic [31:0] w);
    mode_t m;
    m.neg      = w[2:0];
    m.pos      = w[6:4];
    m.on       = w[8];
    m.edge_sel = edge_sel_e'(w[10:9]);
    m.inv      = w[12];
    m.flt_lvl  = w[13];
    m.flt_en   = w[14];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(mode_t m);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = m.neg;
    w[6:4]   = m.pos;
    w[8]     = m.on;
    w[10:9]  = m.edge_sel;
    w[12]    = m.inv;
    w[13]    = m.flt_lvl;
    w[14]    = m.flt_en;
    return w;
  endfunction

  function automatic logic [31:0] ana_to_word(ana_t a);
    return {29'd0, a.hyst, a.bias_hi};
  endfunction

endpackage

// File: rtl/cmpc_sync_edge.sv
`timescale 1ns/1ps
module cmpc_sync_edge
  import cmpc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      raw,
  input  logic      inv,
  input  logic      en,
  input  edge_sel_e edge_sel,
  output logic      level,
  output logic      rise,
  output logic      fall,
  output logic      hit
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              pre_in;

  assign pre_in = raw ^ inv;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain_q[gi] <= 1'b0;
        else if (clr) chain_q[gi] <= 1'b0;
        else          chain_q[gi] <= (gi == 0) ? pre_in : chain_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= 1'b0;
    else if (clr) prev_q <= 1'b0;
    else          prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
  assign hit   = en & edge_match(edge_sel, rise, fall);

endmodule

// File: rtl/cmpc_evt_flag.sv
`timescale 1ns/1ps
module cmpc_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic rd_clr,
  input  logic mask_set,
  input  logic mask_clr,
  output logic flag,
  output logic mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      mask <= 1'b0;
    end else if (clr) begin
      flag <= 1'b0;
      mask <= 1'b0;
    end else begin
      flag <= hit | (flag & ~rd_clr);
      if (mask_set)      mask <= 1'b1;
      else if (mask_clr) mask <= 1'b0;
    end
  end

endmodule

// File: rtl/cmpc_lock.sv
`timescale 1ns/1ps
module cmpc_lock
  import cmpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        key_wr,
  input  logic [23:0] key_in,
  input  logic        lock_in,
  input  logic        guarded_wr,
  input  logic        viol_rd,
  output logic        locked,
  output logic        viol,
  output logic        key_ok,
  output logic        blocked
);

  assign key_ok  = (key_in == LOCK_KEY);
  assign blocked = guarded_wr & locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      viol   <= 1'b0;
    end else if (clr) begin
      locked <= 1'b0;
      viol   <= 1'b0;
    end else begin
      if (key_wr && key_ok) locked <= lock_in;
      viol <= blocked | (viol & ~viol_rd);
    end
  end

endmodule

// File: rtl/cmp_evt_ctrl.sv
`timescale 1ns/1ps
module cmp_evt_ctrl
  import cmpc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              comp_in,
  output logic              irq,
  output logic              fault_out,
  output logic              cmp_on,
  output logic [SEL_W-1:0]  sel_neg,
  output logic [SEL_W-1:0]  sel_pos,
  output logic              bias_hi,
  output logic [HYST_W-1:0] hyst
);

  localparam int FLAG_BIT = 0;
  localparam int LVL_BIT  = 1;
  localparam int MSK_BIT  = DATA_W - 1;

  // Decoded bus events
  logic soft_rst, mode_wr, ana_wr, ien_wr, idis_wr, lock_wr;
  logic stat_rd, viol_rd, guarded_wr;

  assign soft_rst   = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
  assign mode_wr    = bus_wr && (bus_addr == OFS_MODE);
  assign ana_wr     = bus_wr && (bus_addr == OFS_ANA);
  assign ien_wr     = bus_wr && (bus_addr == OFS_IEN)  && bus_wdata[0];
  assign idis_wr    = bus_wr && (bus_addr == OFS_IDIS) && bus_wdata[0];
  assign lock_wr    = bus_wr && (bus_addr == OFS_LOCK);
  assign stat_rd    = bus_rd && (bus_addr == OFS_STAT);
  assign viol_rd    = bus_rd && (bus_addr == OFS_VIOL);
  assign guarded_wr = mode_wr | ana_wr;

  // Protection
  logic locked, viol, key_ok, blocked;

  cmpc_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .key_wr     (lock_wr),
    .key_in     (bus_wdata[31:8]),
    .lock_in    (bus_wdata[0]),
    .guarded_wr (guarded_wr),
    .viol_rd    (viol_rd),
    .locked     (locked),
    .viol       (viol),
    .key_ok     (key_ok),
    .blocked    (blocked)
  );

  // Configuration registers
  mode_t mode_q;
  ana_t  ana_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ana_q  <= '0;
    end else if (soft_rst) begin
      mode_q <= '0;
      ana_q  <= '0;
    end else begin
      if (mode_wr && !locked) mode_q <= mode_from_word(bus_wdata & MODE_KEEP);
      if (ana_wr  && !locked) ana_q  <= '{hyst: bus_wdata[2:1], bias_hi: bus_wdata[0]};
    end
  end

  // Synchronizer and transition detection
  logic sync_lvl, evt_rise, evt_fall, evt_hit;

  cmpc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .raw      (comp_in),
    .inv      (mode_q.inv),
    .en       (mode_q.on),
    .edge_sel (mode_q.edge_sel),
    .level    (sync_lvl),
    .rise     (evt_rise),
    .fall     (evt_fall),
    .hit      (evt_hit)
  );

  // Event flag and interrupt mask
  logic evt_flag, irq_mask;

  cmpc_evt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .hit      (evt_hit),
    .rd_clr   (stat_rd),
    .mask_set (ien_wr),
    .mask_clr (idis_wr),
    .flag     (evt_flag),
    .mask     (irq_mask)
  );

  // Outputs
  assign irq       = evt_flag & irq_mask;
  assign fault_out = fault_pick(mode_q.flt_en, mode_q.flt_lvl, evt_flag, sync_lvl);
  assign cmp_on    = mode_q.on;
  assign sel_neg   = mode_q.neg;
  assign sel_pos   = mode_q.pos;
  assign bias_hi   = ana_q.bias_hi;
  assign hyst      = ana_q.hyst;

  // Read mux
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[FLAG_BIT] = evt_flag;
    stat_word[LVL_BIT]  = sync_lvl;
    stat_word[MSK_BIT]  = irq_mask;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_MODE: bus_rdata = mode_to_word(mode_q);
        OFS_IMSK: bus_rdata = {{(DATA_W-1){1'b0}}, irq_mask};
        OFS_STAT: bus_rdata = stat_word;
        OFS_ANA:  bus_rdata = ana_to_word(ana_q);
        OFS_LOCK: bus_rdata = {{(DATA_W-1){1'b0}}, locked};
        OFS_VIOL: bus_rdata = {{(DATA_W-1){1'b0}}, viol};
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cmpc_checks.sv
`timescale 1ns/1ps
module cmpc_checks
  import cmpc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        evt_hit,
  input logic        evt_flag,
  input logic        stat_rd,
  input logic        cfg_on,
  input logic [1:0]  cfg_edge,
  input logic        cfg_flt_en,
  input logic        fault_out,
  input logic        mode_wr,
  input logic [31:0] mode_word,
  input logic        locked,
  input logic        viol,
  input logic        lock_wr,
  input logic        key_ok
);

  assert_hit_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !soft_rst) |=> evt_flag);

  assert_off_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on |-> !evt_hit);

  assert_code3_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_edge == 2'd3) |-> !evt_hit);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt_hit) |=> !evt_flag);

  assert_fault_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flt_en |-> !fault_out);

  assert_locked_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && mode_wr && !soft_rst) |=> ($stable(mode_word) && viol));

  assert_bad_key_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && !key_ok && !soft_rst) |=> $stable(locked));

endmodule

bind cmp_evt_ctrl cmpc_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .evt_hit    (evt_hit),
  .evt_flag   (evt_flag),
  .stat_rd    (stat_rd),
  .cfg_on     (mode_q.on),
  .cfg_edge   (mode_q.edge_sel),
  .cfg_flt_en (mode_q.flt_en),
  .fault_out  (fault_out),
  .mode_wr    (mode_wr),
  .mode_word  (mode_to_word(mode_q)),
  .locked     (locked),
  .viol       (viol),
  .lock_wr    (lock_wr),
  .key_ok     (key_ok)
);

// File: tb/cmp_evt_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_evt_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        comp_in = 1'b0;
  logic        irq, fault_out, cmp_on, bias_hi;
  logic [2:0]  sel_neg, sel_pos;
  logic [1:0]  hyst;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmp_evt_ctrl u_cmp_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .comp_in(comp_in), .irq(irq), .fault_out(fault_out), .cmp_on(cmp_on),
    .sel_neg(sel_neg), .sel_pos(sel_pos), .bias_hi(bias_hi), .hyst(hyst)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_IEN = 8'h24,
                         A_IDIS = 8'h28, A_IMSK = 8'h2C, A_STAT = 8'h30,
                         A_ANA = 8'h94, A_LOCK = 8'hE4, A_VIOL = 8'hE8;

  // {edge code[1:0], invert, level before, level after, flag expected}
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000011, 6'b000100, 6'b010101, 6'b010010,
    6'b100011, 6'b100101, 6'b110010, 6'b110100,
    6'b001101, 6'b011011, 6'b001010, 6'b101110
  };

  function automatic logic [31:0] mk_mode(logic on, logic [1:0] edg, logic inv,
                                          logic use_lvl, logic flt_en);
    logic [31:0] w;
    w = '0;
    w[8] = on; w[10:9] = edg; w[12] = inv; w[13] = use_lvl; w[14] = flt_en;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Tasks start right after a falling edge and end right after one.
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    bus_read(A_MODE, d); check("R1 mode", d, 0);
    bus_read(A_IMSK, d); check("R1 mask", d, 0);
    bus_read(A_STAT, d); check("R1 status", d, 0);
    bus_read(A_ANA,  d); check("R1 analog", d, 0);
    bus_read(A_LOCK, d); check("R1 lock", d, 0);
    bus_read(A_VIOL, d); check("R1 viol", d, 0);
    check("R1 pins", {irq, fault_out, cmp_on, sel_neg, sel_pos, bias_hi, hyst}, 0);

    // R2 R3 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(A_MODE, mk_mode(1'b1, VEC[i][5:4], VEC[i][3], 1'b0, 1'b0));
      comp_in = VEC[i][2];
      wait_cyc(5);
      bus_read(A_STAT, d);
      comp_in = VEC[i][1];
      wait_cyc(4);
      bus_read(A_STAT, d);
      check(VEC[i][3] ? "R5 inverted flag" : "R3 edge flag", {31'd0, d[0]}, {31'd0, VEC[i][0]});
      check("R2 level", {31'd0, d[1]}, {31'd0, VEC[i][1] ^ VEC[i][3]});
    end

    // R2 timing: level visible after two edges, not one
    bus_write(A_MODE, mk_mode(1'b1, 2'd2, 1'b0, 1'b0, 1'b0));
    comp_in = 1'b0; wait_cyc(5); bus_read(A_STAT, d);
    comp_in = 1'b1; wait_cyc(1);
    bus_read(A_STAT, d); check("R2 one edge", {31'd0, d[1]}, 0);
    bus_read(A_STAT, d); check("R2 two edges", {31'd0, d[1]}, 1);
    wait_cyc(3); bus_read(A_STAT, d);

    // R4 disabled: no flag, level still tracked
    bus_write(A_MODE, mk_mode(1'b0, 2'd2, 1'b0, 1'b0, 1'b0));
    wait_cyc(4); bus_read(A_STAT, d);
    comp_in = 1'b0; wait_cyc(4);
    bus_read(A_STAT, d); check("R4 no flag when off", d[1:0], 2'b00);
    comp_in = 1'b1; wait_cyc(4);
    bus_read(A_STAT, d); check("R4 level when off", d[1:0], 2'b10);

    // R6 same-cycle hit and read
    bus_write(A_MODE, mk_mode(1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    comp_in = 1'b0; wait_cyc(5); bus_read(A_STAT, d);
    comp_in = 1'b1; wait_cyc(2);
    bus_read(A_STAT, d); check("R6 read during hit", {31'd0, d[0]}, 0);
    bus_read(A_STAT, d); check("R6 flag kept", {31'd0, d[0]}, 1);
    bus_read(A_STAT, d); check("R6 flag cleared", {31'd0, d[0]}, 0);

    // R7 mask and irq
    comp_in = 1'b0; wait_cyc(4); comp_in = 1'b1; wait_cyc(4);
    check("R7 irq masked", {31'd0, irq}, 0);
    bus_write(A_IEN, 32'h1);
    bus_read(A_IMSK, d); check("R7 mask set", d, 1);
    check("R7 irq on", {31'd0, irq}, 1);
    bus_read(A_STAT, d); check("R7 status word", d, 32'h8000_0003);
    check("R7 irq after clear", {31'd0, irq}, 0);
    bus_write(A_IDIS, 32'h1);
    bus_read(A_IMSK, d); check("R7 mask cleared", d, 0);

    // R8 fault source
    bus_write(A_MODE, mk_mode(1'b1, 2'd0, 1'b0, 1'b1, 1'b1));
    comp_in = 1'b0; wait_cyc(4);
    check("R8 level low", {31'd0, fault_out}, 0);
    comp_in = 1'b1; wait_cyc(4);
    check("R8 level high", {31'd0, fault_out}, 1);
    bus_write(A_MODE, mk_mode(1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
    comp_in = 1'b0; wait_cyc(4); bus_read(A_STAT, d);
    check("R8 flag low", {31'd0, fault_out}, 0);
    comp_in = 1'b1; wait_cyc(4);
    check("R8 flag high", {31'd0, fault_out}, 1);
    bus_write(A_MODE, mk_mode(1'b1, 2'd0, 1'b0, 1'b1, 1'b0));
    wait_cyc(1);
    check("R8 gated", {31'd0, fault_out}, 0);
    bus_read(A_STAT, d);

    // R9 masks and field pins
    bus_write(A_MODE, 32'hFFFF_FFFF);
    bus_read(A_MODE, d); check("R9 mode mask", d, 32'h7777);
    check("R9 pins all", {25'd0, cmp_on, sel_neg, sel_pos}, 32'h7F);
    bus_write(A_MODE, 32'h0000_0025);
    check("R9 pins pattern", {25'd0, cmp_on, sel_neg, sel_pos}, {25'd0, 1'b0, 3'd5, 3'd2});
    bus_write(A_ANA, 32'hFFFF_FFFF);
    bus_read(A_ANA, d); check("R9 analog mask", d, 7);
    check("R9 analog pins", {29'd0, hyst, bias_hi}, 7);
    bus_write(A_ANA, 32'h0000_0004);
    check("R9 analog pattern", {29'd0, hyst, bias_hi}, 32'h4);

    // R10 key
    bus_write(A_LOCK, 32'h4143_4201);
    bus_read(A_LOCK, d); check("R10 bad key", d, 0);
    bus_write(A_LOCK, 32'h4143_4301);
    bus_read(A_LOCK, d); check("R10 good key", d, 1);

    // R11 locked writes
    bus_write(A_MODE, 32'h0000_0777);
    bus_read(A_MODE, d); check("R11 mode kept", d, 32'h25);
    bus_read(A_VIOL, d); check("R11 viol set", d, 1);
    bus_read(A_VIOL, d); check("R11 viol cleared", d, 0);
    bus_write(A_ANA, 32'h0000_0003);
    bus_read(A_ANA, d); check("R11 analog kept", d, 4);
    bus_read(A_VIOL, d); check("R11 viol analog", d, 1);
    bus_write(A_LOCK, 32'h4143_4300);
    bus_write(A_MODE, 32'h0000_0105);
    bus_read(A_MODE, d); check("R11 unlocked write", d, 32'h105);

    // R12 soft reset
    bus_write(A_IEN, 32'h1);
    bus_write(A_LOCK, 32'h4143_4301);
    bus_write(A_CTRL, 32'h1);
    bus_read(A_MODE, d); check("R12 mode", d, 0);
    bus_read(A_IMSK, d); check("R12 mask", d, 0);
    bus_read(A_ANA,  d); check("R12 analog", d, 0);
    bus_read(A_LOCK, d); check("R12 lock", d, 0);

    summary();
  end

endmodule